// File: doc/BRIEF.md
# Sleep Interval Timer with Watchdog

This block divides a slow 32 kHz tick stream into periodic wake-up events and watches for stalled software. It runs on the fast system clock. Two single-cycle tick enables come in, one from a low-speed on-chip oscillator and one from a 32.768 kHz crystal. A source bit chooses which of them advances a free-running counter. A 3-bit interval code sets the spacing of the events. The code is made of an extension bit and a 2-bit step field. On each boundary of the selected interval the block issues a one-cycle sleep interrupt.

The watchdog counts those interrupts. Software must strobe the watchdog clear before the third interrupt arrives, so the time allowed is close to three sleep periods. If the clear does not come in time, the block issues a one-cycle reset pulse. A separate timer clear restarts the interval counter from zero. The oscillators, power duty-cycling and the sleep controller are outside this block.

Top module: `slp_wdt_timer`

## Requirements
- R1: After synchronous reset `sleep_irq` and `wdt_rst` are low, the counter is zero and the active interval code is 000, so the first interrupt follows the 64th counted tick.
- R2: With `src_xtal` = 0 only `tick_lo` advances the counter. With `src_xtal` = 1 only `tick_xt` does. Ticks on the source that is not selected have no effect.
- R3: The interval code is {`ivl_ext`, `ivl_step`}. With `ivl_ext` = 0, steps 00, 01, 10 and 11 give periods of 64, 512, 4096 and 32768 ticks.
- R4: With `ivl_ext` = 1, steps 00, 01, 10 and 11 give periods of 65536, 131072, 262144 and 524288 ticks.
- R5: `sleep_irq` is high for exactly one cycle. That cycle follows the clock edge that samples the tick bringing the counter to a multiple of the active period.
- R6: A new interval code is adopted only on a boundary of the active period, or by a timer clear. A change between boundaries produces no interrupt before the current period ends.
- R7: `tmr_clr` sets the counter to zero, adopts the requested code at once and suppresses any interrupt on that edge. It leaves the watchdog event count unchanged.
- R8: While `wdt_en` is high the watchdog counts interrupts. The third interrupt without an intervening clear raises `wdt_rst` for one cycle, in the cycle after that interrupt, and the count returns to zero.
- R9: `wdt_kick` sets the watchdog event count to zero and does not move the counter phase.
- R10: When `wdt_kick` is high in the same cycle as `sleep_irq`, the clear wins. That interrupt is not counted and no reset pulse follows.
- R11: While `wdt_en` is low the event count is held at zero and `wdt_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_lo | input | 1 | Tick enable from the low-speed internal oscillator |
| tick_xt | input | 1 | Tick enable from the crystal oscillator |
| src_xtal | input | 1 | Tick source select, 1 selects the crystal |
| ivl_ext | input | 1 | Interval extension bit (code bit 2) |
| ivl_step | input | 2 | Interval step field (code bits 1:0) |
| wdt_en | input | 1 | Watchdog enable |
| wdt_kick | input | 1 | Watchdog clear strobe |
| tmr_clr | input | 1 | Interval counter clear |
| sleep_irq | output | 1 | One-cycle sleep interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The watchdog clear and the sleep interrupt can fall in the same cycle. The same holds for the timer clear and a tick that completes a period. The bench provokes the first by driving `wdt_kick` in exactly the cycles where its model predicts `sleep_irq` is high. It then expects no reset pulse at all, and a full three-event count once the clears stop. It provokes the second with random timer clears under ticks on every cycle, and judges each output cycle against a model that gives the clear priority over the boundary.

// File: rtl/slp_wdt_pkg.sv
package slp_wdt_pkg;

    localparam int CODE_W     = 3;
    localparam int SHIFT_W    = 5;
    localparam int CNT_W_DFLT = 19;
    localparam int WDT_EVENTS = 3;

    typedef logic [CODE_W-1:0]  ivl_code_t;
    typedef logic [SHIFT_W-1:0] ivl_shift_t;

    typedef enum logic {
        SRC_LOW  = 1'b0,
        SRC_XTAL = 1'b1
    } tick_src_t;

    typedef struct packed {
        logic       ext;
        logic [1:0] step;
    } ivl_req_t;

    function automatic ivl_code_t req_to_code(ivl_req_t r);
        return {r.ext, r.step};
    endfunction

    // log2 of the period in ticks for each interval code
    function automatic ivl_shift_t code_to_shift(ivl_code_t c);
        ivl_shift_t s;
        case (c)
            3'd0:    s = 5'd6;
            3'd1:    s = 5'd9;
            3'd2:    s = 5'd12;
            3'd3:    s = 5'd15;
            3'd4:    s = 5'd16;
            3'd5:    s = 5'd17;
            3'd6:    s = 5'd18;
            default: s = 5'd19;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slp_tick_select.sv
module slp_tick_select
    import slp_wdt_pkg::*;
(
    input  tick_src_t src,
    input  logic      tick_lo,
    input  logic      tick_xt,
    output logic      tick
);
    always_comb begin
        unique case (src)
            SRC_XTAL: tick = tick_xt;
            default:  tick = tick_lo;
        endcase
    end
endmodule

// File: rtl/slp_interval_counter.sv
module slp_interval_counter
    import slp_wdt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DFLT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      clr,
    input  ivl_code_t req_code,
    output ivl_code_t act_code,
    output logic      irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] low_mask;
    ivl_shift_t       shift;
    logic             hit;

    always_comb begin
        shift    = code_to_shift(act_code);
        cnt_inc  = cnt_q + CNT_W'(1);
        low_mask = (CNT_W'(1) << shift) - CNT_W'(1);
        hit      = tick && ((cnt_inc & low_mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            act_code <= '0;
            irq      <= 1'b0;
        end else if (clr) begin
            cnt_q    <= '0;
            act_code <= req_code;
            irq      <= 1'b0;
        end else begin
            irq <= hit;
            if (tick) begin
                cnt_q <= cnt_inc;
            end
            if (hit) begin
                act_code <= req_code;
            end
        end
    end
endmodule

// File: rtl/slp_watchdog.sv
module slp_watchdog #(
    parameter int EVENTS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic kick,
    input  logic evt,
    output logic bite
);
    localparam int EV_W = (EVENTS > 2) ? $clog2(EVENTS) : 1;
    localparam logic [EV_W-1:0] LAST = EV_W'(EVENTS - 1);

    logic [EV_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            bite   <= 1'b0;
        end else begin
            bite <= 1'b0;
            if (!en || kick) begin
                seen_q <= '0;
            end else if (evt) begin
                if (seen_q == LAST) begin
                    seen_q <= '0;
                    bite   <= 1'b1;
                end else begin
                    seen_q <= seen_q + EV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/slp_wdt_timer.sv
module slp_wdt_timer
    import slp_wdt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DFLT,
    parameter int EVENTS = WDT_EVENTS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_lo,
    input  logic       tick_xt,
    input  logic       src_xtal,
    input  logic       ivl_ext,
    input  logic [1:0] ivl_step,
    input  logic       wdt_en,
    input  logic       wdt_kick,
    input  logic       tmr_clr,
    output logic       sleep_irq,
    output logic       wdt_rst
);
    tick_src_t src;
    ivl_req_t  req;
    ivl_code_t req_code;
    ivl_code_t cur_code;
    logic      sel_tick;

    assign src      = tick_src_t'(src_xtal);
    assign req      = '{ext: ivl_ext, step: ivl_step};
    assign req_code = req_to_code(req);

    slp_tick_select u_sel (
        .src     (src),
        .tick_lo (tick_lo),
        .tick_xt (tick_xt),
        .tick    (sel_tick)
    );

    slp_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (sel_tick),
        .clr      (tmr_clr),
        .req_code (req_code),
        .act_code (cur_code),
        .irq      (sleep_irq)
    );

    slp_watchdog #(.EVENTS(EVENTS)) u_wdt (
        .clk  (clk),
        .rst  (rst),
        .en   (wdt_en),
        .kick (wdt_kick),
        .evt  (sleep_irq),
        .bite (wdt_rst)
    );
endmodule

// File: rtl/slp_wdt_timer_chk.sv
module slp_wdt_timer_chk
    import slp_wdt_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sel_tick,
    input logic      tmr_clr,
    input logic      wdt_en,
    input logic      wdt_kick,
    input logic      sleep_irq,
    input logic      wdt_rst,
    input ivl_code_t cur_code
);
    p_irq_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        sleep_irq |-> $past(sel_tick));

    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        sleep_irq |=> !sleep_irq);

    p_code_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_code) |-> ($past(tmr_clr) || sleep_irq));

    p_clr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        tmr_clr |=> !sleep_irq);

    p_bite_after_irq_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> $past(sleep_irq));

    p_bite_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    p_kick_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        wdt_kick |=> !wdt_rst);

    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdt_rst);
endmodule

bind slp_wdt_timer slp_wdt_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_tick  (sel_tick),
    .tmr_clr   (tmr_clr),
    .wdt_en    (wdt_en),
    .wdt_kick  (wdt_kick),
    .sleep_irq (sleep_irq),
    .wdt_rst   (wdt_rst),
    .cur_code  (cur_code)
);

// File: tb/slp_wdt_timer_bench.sv
module slp_wdt_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_lo = 1'b0, tick_xt = 1'b0, src_xtal = 1'b0;
    logic       ivl_ext = 1'b0;
    logic [1:0] ivl_step = 2'd0;
    logic       wdt_en = 1'b0, wdt_kick = 1'b0, tmr_clr = 1'b0;
    logic       sleep_irq, wdt_rst;

    int    n_chk = 0, n_err = 0, ncyc = 0;
    string tag = "R1";
    bit    done = 0;

    // reference model state
    int unsigned m_cnt = 0;
    int unsigned m_act = 0;
    int unsigned m_wc  = 0;
    logic        e_irq = 1'b0, e_rst = 1'b0;

    always #4 clk = ~clk;

    slp_wdt_timer u_slp_wdt_timer (
        .clk(clk), .rst(rst), .tick_lo(tick_lo), .tick_xt(tick_xt),
        .src_xtal(src_xtal), .ivl_ext(ivl_ext), .ivl_step(ivl_step),
        .wdt_en(wdt_en), .wdt_kick(wdt_kick), .tmr_clr(tmr_clr),
        .sleep_irq(sleep_irq), .wdt_rst(wdt_rst)
    );

    function automatic int unsigned period_of(int unsigned code);
        case (code)
            0: return 64;      1: return 512;
            2: return 4096;    3: return 32768;
            4: return 65536;   5: return 131072;
            6: return 262144;  default: return 524288;
        endcase
    endfunction

    task automatic chk(string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", tag, what, ncyc, act, exp);
        end
    endtask

    task automatic cycle();
        logic        tk, old_irq;
        int unsigned nxt;
        old_irq = e_irq;
        if (rst) begin
            m_cnt = 0; m_act = 0; m_wc = 0; e_irq = 0; e_rst = 0;
        end else begin
            if (!wdt_en || wdt_kick) begin
                m_wc = 0; e_rst = 0;
            end else if (old_irq) begin
                if (m_wc == 2) begin m_wc = 0; e_rst = 1; end
                else begin m_wc++; e_rst = 0; end
            end else e_rst = 0;
            tk = src_xtal ? tick_xt : tick_lo;
            e_irq = 0;
            if (tmr_clr) begin
                m_cnt = 0; m_act = {ivl_ext, ivl_step};
            end else if (tk) begin
                nxt = (m_cnt + 1) % 524288;
                if (nxt % period_of(m_act) == 0) begin
                    e_irq = 1; m_act = {ivl_ext, ivl_step};
                end
                m_cnt = nxt;
            end
        end
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        chk("sleep_irq", sleep_irq, e_irq);
        chk("wdt_rst", wdt_rst, e_rst);
    endtask

    task automatic set_code(int unsigned c);
        ivl_ext = c[2]; ivl_step = c[1:0];
    endtask

    task automatic restart(int unsigned c);
        set_code(c); tmr_clr = 1; cycle(); tmr_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        wait (ncyc >= 195000);
        tag = "watchdog";
        n_chk++; n_err++;
        $display("FAIL %s run did not finish", tag);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1; cycle(); cycle();
        rst = 0;
        // R1: reset values and default 64-tick period
        tag = "R1";
        chk("sleep_irq", sleep_irq, 1'b0);
        chk("wdt_rst", wdt_rst, 1'b0);
        tick_lo = 1;
        for (int i = 0; i < 140; i++) cycle();

        // R2: low source selected, crystal ticks random and ignored
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            tick_lo = ($urandom % 2) == 0; tick_xt = ($urandom % 3) == 0; cycle();
        end
        src_xtal = 1;
        for (int i = 0; i < 600; i++) begin
            tick_xt = ($urandom % 2) == 0; tick_lo = ($urandom % 3) == 0; cycle();
        end
        src_xtal = 0; tick_lo = 1; tick_xt = 0;

        // R3: short ladder, full period each
        tag = "R3";
        for (int c = 0; c < 4; c++) begin
            restart(c);
            for (int i = 0; i < int'(period_of(c)) + 8; i++) cycle();
        end

        // R4: long ladder, first code full, others checked for no early event
        tag = "R4";
        restart(4);
        for (int i = 0; i < 65544; i++) cycle();
        for (int c = 5; c < 8; c++) begin
            restart(c);
            for (int i = 0; i < 3000; i++) cycle();
        end

        // R6: interval change mid-period
        tag = "R6";
        restart(1);
        for (int i = 0; i < 100; i++) cycle();
        set_code(0);
        for (int i = 0; i < 1200; i++) cycle();
        set_code(2);
        for (int i = 0; i < 30; i++) cycle();
        set_code(0);
        for (int i = 0; i < 600; i++) cycle();

        // R5 / R8 / R9: random ticks, enabled watchdog, rare kicks
        tag = "R8";
        restart(0);
        wdt_en = 1;
        for (int i = 0; i < 6000; i++) begin
            tick_lo = ($urandom % 2) == 0;
            wdt_kick = ($urandom % 300) == 0;
            cycle();
        end
        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            tick_lo = 1;
            wdt_kick = ($urandom % 90) == 0;
            cycle();
        end
        wdt_kick = 0;

        // R10: clear coincident with every interrupt
        tag = "R10";
        for (int i = 0; i < 1500; i++) begin
            wdt_kick = e_irq; cycle();
        end
        wdt_kick = 0;
        tag = "R5";
        for (int i = 0; i < 400; i++) cycle();

        // R11: watchdog disabled
        tag = "R11";
        wdt_en = 0;
        for (int i = 0; i < 800; i++) begin
            wdt_kick = ($urandom % 50) == 0; cycle();
        end
        wdt_kick = 0; wdt_en = 1;
        for (int i = 0; i < 300; i++) cycle();

        // R7: random timer clears with random codes, watchdog running
        tag = "R7";
        for (int i = 0; i < 8000; i++) begin
            tick_lo = ($urandom % 4) != 0;
            tmr_clr = ($urandom % 400) == 0;
            if (tmr_clr) set_code($urandom % 2);
            cycle();
        end
        tmr_clr = 0;
        finish_run();
    end
endmodule